// File: doc/BRIEF.md
# Tile Power-Gating Sequencer

This block steps one processor tile through a controlled power-down and a later wake-up. Software talks to it over a simple 32-bit register bus with a write strobe, an address and write data, and a read path that is decoded directly from the address. Power-down happens in two phases. In the first, software asks for preparation. The unit raises a request to an external power-management controller and answers with an acknowledge plus a set of coded rejection reasons. In the second, software arms the gate. The tile is then powered off only once the core reports that it has halted.

Power-down asserts isolation first, then tile reset, and then removes the power switch enable. Wake-up runs the same steps in reverse. Power returns first, and the unit waits a programmable settle count. It then lifts isolation, and finally releases reset with a warm-reset flag set. A stored 64-bit resume address is held across the gated period and presented to the core. A wake event can abort the request at any stage before power is removed. Separate disable requests cancel a prepared state or an armed gate.

Top module: `tile_pwr_seq`

## Requirements
- R1: After reset, the pins read pmc_req=0, iso_en=0, tile_rst=0, pwr_en=1 and warm_boot=0. Offsets 0x00 and 0x04 read 0, offset 0x20 reads 0x1 (wake enabled), and offset 0x24 reads the default settle count of 4.
- R2: Writing offset 0x00 with bit 31 set raises pmc_req on the next cycle. When pmc_grant, pmc_deny or pmc_fail arrives, bit 30 (acknowledge) is set. At the same moment the response bits are captured: bit 18 for cache not quiet, bit 17 for pmc_fail, bit 16 for pmc_deny and bit 15 for bus_err.
- R3: A wake event while the prepare phase waits for the power controller sets bits 30, 12 and 2 of offset 0x00 and clears bit 31. The tile stays running and pmc_req drops.
- R4: Once prepared, a bus error, a loss of cache quiescence or a wake event sets bit 15, 18 or 12 of offset 0x00 on the next cycle, with no new request.
- R5: Writing bit 29 of offset 0x00 cancels a prepared or rejected state. The unit returns to running, drops pmc_req, clears bit 29 and sets bit 28. This also works after an error response or an abort.
- R6: A write carrying bit 31 or bit 29 to offset 0x00 or 0x04 clears that register's acknowledge, response, abort and warm bits in the same cycle.
- R7: Bit 31 of offset 0x04 arms the gate only in the prepared state. The gate fires only when core_halted is seen, which sets bit 30. Bit 17 (pmc_fail), bit 16 (pmc_deny), bit 15 (bus_err) or bit 14 (master not quiet) at that moment block power-down and return the unit to the prepared state.
- R8: Power-down asserts iso_en one cycle after core_halted is seen. tile_rst follows one cycle later, and pwr_en falls one cycle after that.
- R9: A wake event while armed but not halted, even in the same cycle as core_halted, aborts gating. It sets bit 12 of offset 0x00, clears bit 31 of offset 0x04 and never raises iso_en.
- R10: A wake event while gated restores pwr_en on the next cycle and clears bit 31 of both offsets 0x00 and 0x04. iso_en then stays on for settle+1 cycles, where settle is offset 0x24 bits 7:0. tile_rst falls one cycle after iso_en, and bit 1 of offset 0x04 (warm_boot) is then set.
- R11: Offsets 0x10 (low) and 0x14 (high) store the 64-bit resume_pc and read back. The value is unchanged across a gated period.
- R12: A write to offset 0x20 with bit 31 set loads bit 0 (wake enable) and sets bit 30. While bit 0 is 0, wake_in is ignored, and a gated tile stays gated.
- R13: Writing bit 29 of offset 0x04 while armed returns the unit to the prepared state, clears bit 31 and sets bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| core_halted | input | 1 | Core has stopped executing |
| wake_in | input | 1 | Wake event |
| cache_quiet | input | 1 | Private cache is quiescent |
| master_quiet | input | 1 | Tile bus masters are quiescent |
| bus_err | input | 1 | Interconnect error |
| pmc_req | output | 1 | Request to power-management controller |
| pmc_grant | input | 1 | Controller grants request |
| pmc_deny | input | 1 | Controller denies request |
| pmc_fail | input | 1 | Controller enable error |
| iso_en | output | 1 | Isolation enable |
| pwr_en | output | 1 | Power switch enable |
| tile_rst | output | 1 | Tile reset |
| resume_pc | output | 64 | Resume address for the core |
| warm_boot | output | 1 | Warm-reset flag |

## Verification
A wake event and the core-halted indication can land in the same cycle while the gate is armed. Here the abort must win over the power-down. The bench drives both inputs high before the same clock edge. It then checks that isolation never rises, that the pins keep the tile powered, that the wake bit is set in the prepare word and that the gate request bit is gone. A second overlap is a register write that lands in the same cycle as a state update. The bench judges it by reading back the cleared acknowledge bits immediately after the write.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;

  typedef enum logic [3:0] {
    ST_RUN, ST_PREP, ST_READY, ST_ARMED,
    ST_DN_ISO, ST_DN_RST, ST_GATED, ST_UP_SETTLE, ST_UP_ISO
  } tpg_state_e;

  localparam int unsigned OFS_PREP   = 'h00;
  localparam int unsigned OFS_GATE   = 'h04;
  localparam int unsigned OFS_PC_LO  = 'h10;
  localparam int unsigned OFS_PC_HI  = 'h14;
  localparam int unsigned OFS_WMASK  = 'h20;
  localparam int unsigned OFS_SETTLE = 'h24;

  // handshake field positions shared by both control words
  localparam int B_ENA_REQ = 31;
  localparam int B_ENA_ACK = 30;
  localparam int B_DIS_REQ = 29;
  localparam int B_DIS_ACK = 28;
  // response fields
  localparam int B_CACHE_NQ = 18;
  localparam int B_PMC_FAIL = 17;
  localparam int B_PMC_DENY = 16;
  localparam int B_BUS_ERR  = 15;
  localparam int B_MAST_NQ  = 14;
  localparam int B_WAKE     = 12;
  localparam int B_ABORT    = 2;
  localparam int B_WARM     = 1;

  typedef struct packed {
    logic ena_req;
    logic ena_ack;
    logic dis_req;
    logic dis_ack;
  } hs_t;

  // resp = {cache_nq, pmc_fail, pmc_deny, bus_err, wake}
  function automatic logic [31:0] prep_word(hs_t h, logic [4:0] resp, logic abort);
    logic [31:0] w;
    w = '0;
    w[B_ENA_REQ] = h.ena_req;  w[B_ENA_ACK] = h.ena_ack;
    w[B_DIS_REQ] = h.dis_req;  w[B_DIS_ACK] = h.dis_ack;
    w[B_CACHE_NQ] = resp[4];   w[B_PMC_FAIL] = resp[3];
    w[B_PMC_DENY] = resp[2];   w[B_BUS_ERR]  = resp[1];
    w[B_WAKE]     = resp[0];   w[B_ABORT]    = abort;
    return w;
  endfunction

  // resp = {pmc_fail, pmc_deny, bus_err, mast_nq}
  function automatic logic [31:0] gate_word(hs_t h, logic [3:0] resp, logic warm);
    logic [31:0] w;
    w = '0;
    w[B_ENA_REQ] = h.ena_req;  w[B_ENA_ACK] = h.ena_ack;
    w[B_DIS_REQ] = h.dis_req;  w[B_DIS_ACK] = h.dis_ack;
    w[B_PMC_FAIL] = resp[3];   w[B_PMC_DENY] = resp[2];
    w[B_BUS_ERR]  = resp[1];   w[B_MAST_NQ]  = resp[0];
    w[B_WARM]     = warm;
    return w;
  endfunction

endpackage

// File: rtl/tpg_settle_timer.sv
`timescale 1ns/1ps
module tpg_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  output logic         done
);
  logic [W-1:0] cnt;
  logic         busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= load;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // the count window closes exactly once per start (R10)
  assert_done_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

endmodule

// File: rtl/tpg_seq.sv
`timescale 1ns/1ps
module tpg_seq
  import tpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prep_wr,
  input  logic        gate_wr,
  input  logic        w_ena,
  input  logic        w_dis,
  input  logic        wake,
  input  logic        core_halted,
  input  logic        cache_quiet,
  input  logic        master_quiet,
  input  logic        bus_err,
  input  logic        pmc_grant,
  input  logic        pmc_deny,
  input  logic        pmc_fail,
  input  logic        settle_done,
  output logic        settle_start,
  output logic        pmc_req,
  output logic        iso_en,
  output logic        tile_rst,
  output logic        pwr_en,
  output logic        warm,
  output logic [31:0] prep_word_o,
  output logic [31:0] gate_word_o
);
  tpg_state_e state_q;
  hs_t        ph, gh;
  logic [4:0] p_resp;
  logic       p_abort;
  logic [3:0] g_resp;
  logic       g_warm;

  logic       p_take, g_take, pmc_answer;
  logic [4:0] live;
  logic [3:0] g_now;
  logic       ev_prep_abort, ev_gate_fire;

  assign p_take     = prep_wr && (w_ena || w_dis);
  assign g_take     = gate_wr && (w_ena || w_dis);
  assign pmc_answer = pmc_grant || pmc_deny || pmc_fail;
  assign live       = {~cache_quiet, 1'b0, 1'b0, bus_err, wake};
  assign g_now      = {pmc_fail, pmc_deny, bus_err, ~master_quiet};

  assign ev_prep_abort = (state_q == ST_PREP) && wake;
  assign ev_gate_fire  = (state_q == ST_ARMED) && !wake && !gh.dis_req &&
                         core_halted && (g_now == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      ph      <= '0;
      gh      <= '0;
      p_resp  <= '0;
      p_abort <= 1'b0;
      g_resp  <= '0;
      g_warm  <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (ph.dis_req) begin
            ph.dis_ack <= 1'b1; ph.dis_req <= 1'b0; ph.ena_req <= 1'b0;
          end else if (ph.ena_req && !ph.ena_ack) begin
            state_q <= ST_PREP;
          end
          if (gh.dis_req) begin
            gh.dis_ack <= 1'b1; gh.dis_req <= 1'b0; gh.ena_req <= 1'b0;
          end
        end
        ST_PREP: begin
          if (wake) begin
            ph.ena_ack <= 1'b1; ph.ena_req <= 1'b0;
            p_resp[0]  <= 1'b1; p_abort    <= 1'b1;
            state_q    <= ST_RUN;
          end else if (ph.dis_req) begin
            ph.dis_ack <= 1'b1; ph.dis_req <= 1'b0; ph.ena_req <= 1'b0;
            state_q    <= ST_RUN;
          end else if (pmc_answer) begin
            ph.ena_ack <= 1'b1;
            p_resp     <= {~cache_quiet, pmc_fail, pmc_deny, bus_err, 1'b0};
            state_q    <= ST_READY;
          end
        end
        ST_READY: begin
          p_resp <= p_resp | live;
          if (ph.dis_req) begin
            ph.dis_ack <= 1'b1; ph.dis_req <= 1'b0; ph.ena_req <= 1'b0;
            gh.ena_req <= 1'b0;
            state_q    <= ST_RUN;
          end else if (gh.dis_req) begin
            gh.dis_ack <= 1'b1; gh.dis_req <= 1'b0; gh.ena_req <= 1'b0;
          end else if (gh.ena_req && !gh.ena_ack) begin
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          p_resp <= p_resp | live;
          if (wake) begin
            gh.ena_req <= 1'b0;
            state_q    <= ST_READY;
          end else if (gh.dis_req) begin
            gh.dis_ack <= 1'b1; gh.dis_req <= 1'b0; gh.ena_req <= 1'b0;
            state_q    <= ST_READY;
          end else if (core_halted) begin
            gh.ena_ack <= 1'b1;
            g_resp     <= g_now;
            if (g_now != '0) begin
              gh.ena_req <= 1'b0;
              state_q    <= ST_READY;
            end else begin
              state_q <= ST_DN_ISO;
            end
          end
        end
        ST_DN_ISO: state_q <= ST_DN_RST;
        ST_DN_RST: state_q <= ST_GATED;
        ST_GATED: begin
          if (wake) begin
            ph.ena_req <= 1'b0;
            gh.ena_req <= 1'b0;
            state_q    <= ST_UP_SETTLE;
          end
        end
        ST_UP_SETTLE: if (settle_done) state_q <= ST_UP_ISO;
        ST_UP_ISO: begin
          g_warm  <= 1'b1;
          state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
      // a fresh request write overrides the state update of the same cycle
      if (p_take) begin
        ph      <= '{w_ena, 1'b0, w_dis, 1'b0};
        p_resp  <= '0;
        p_abort <= 1'b0;
      end
      if (g_take) begin
        gh     <= '{w_ena, 1'b0, w_dis, 1'b0};
        g_resp <= '0;
        g_warm <= 1'b0;
      end
    end
  end

  assign settle_start = (state_q == ST_GATED) && wake;
  assign pmc_req  = state_q inside {ST_PREP, ST_READY, ST_ARMED, ST_DN_ISO, ST_DN_RST, ST_GATED};
  assign iso_en   = state_q inside {ST_DN_ISO, ST_DN_RST, ST_GATED, ST_UP_SETTLE};
  assign tile_rst = state_q inside {ST_DN_RST, ST_GATED, ST_UP_SETTLE, ST_UP_ISO};
  assign pwr_en   = (state_q != ST_GATED);
  assign warm     = g_warm;
  assign prep_word_o = prep_word(ph, p_resp, p_abort);
  assign gate_word_o = gate_word(gh, g_resp, g_warm);

  assert_abort_acks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prep_abort && !p_take) |=> (ph.ena_ack && p_abort && !pmc_req));
  assert_fire_isolates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gate_fire |=> (iso_en && pwr_en && !tile_rst));
  assert_iso_needs_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_en) |-> $past(core_halted));
  assert_rst_after_iso_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tile_rst) |-> $past(iso_en));
  assert_off_after_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(tile_rst) && iso_en));
  assert_iso_drop_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (tile_rst && pwr_en));

endmodule

// File: rtl/tile_pwr_seq.sv
`timescale 1ns/1ps
module tile_pwr_seq
  import tpg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SETTLE_W    = 8,
  parameter int SETTLE_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_halted,
  input  logic              wake_in,
  input  logic              cache_quiet,
  input  logic              master_quiet,
  input  logic              bus_err,
  output logic              pmc_req,
  input  logic              pmc_grant,
  input  logic              pmc_deny,
  input  logic              pmc_fail,
  output logic              iso_en,
  output logic              pwr_en,
  output logic              tile_rst,
  output logic [63:0]       resume_pc,
  output logic              warm_boot
);
  localparam int WORD_W = 32;
  localparam int PC_W   = 2 * WORD_W;

  logic [WORD_W-1:0]   pc_lo, pc_hi;
  logic                wake_en, wm_ack;
  logic [SETTLE_W-1:0] settle_q;
  logic [31:0]         prep_w, gate_w;
  logic                wake, settle_start, settle_done;
  logic                wr_prep, wr_gate, wr_lo, wr_hi, wr_wm, wr_settle;

  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_prep   = bus_wr && hit(bus_addr, OFS_PREP);
  assign wr_gate   = bus_wr && hit(bus_addr, OFS_GATE);
  assign wr_lo     = bus_wr && hit(bus_addr, OFS_PC_LO);
  assign wr_hi     = bus_wr && hit(bus_addr, OFS_PC_HI);
  assign wr_wm     = bus_wr && hit(bus_addr, OFS_WMASK);
  assign wr_settle = bus_wr && hit(bus_addr, OFS_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_lo    <= '0;
      pc_hi    <= '0;
      wake_en  <= 1'b1;
      wm_ack   <= 1'b0;
      settle_q <= SETTLE_W'(SETTLE_INIT);
    end else begin
      if (wr_lo)     pc_lo    <= bus_wdata;
      if (wr_hi)     pc_hi    <= bus_wdata;
      if (wr_settle) settle_q <= bus_wdata[SETTLE_W-1:0];
      if (wr_wm) begin
        wm_ack <= bus_wdata[B_ENA_REQ];
        if (bus_wdata[B_ENA_REQ]) wake_en <= bus_wdata[0];
      end
    end
  end

  assign wake      = wake_in && wake_en;
  assign resume_pc = PC_W'({pc_hi, pc_lo});

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_PREP))   bus_rdata = prep_w;
    if (hit(bus_addr, OFS_GATE))   bus_rdata = gate_w;
    if (hit(bus_addr, OFS_PC_LO))  bus_rdata = pc_lo;
    if (hit(bus_addr, OFS_PC_HI))  bus_rdata = pc_hi;
    if (hit(bus_addr, OFS_WMASK))  bus_rdata = {1'b0, wm_ack, 29'd0, wake_en};
    if (hit(bus_addr, OFS_SETTLE)) bus_rdata = 32'(settle_q);
  end

  tpg_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .prep_wr     (wr_prep),
    .gate_wr     (wr_gate),
    .w_ena       (bus_wdata[B_ENA_REQ]),
    .w_dis       (bus_wdata[B_DIS_REQ]),
    .wake        (wake),
    .core_halted (core_halted),
    .cache_quiet (cache_quiet),
    .master_quiet(master_quiet),
    .bus_err     (bus_err),
    .pmc_grant   (pmc_grant),
    .pmc_deny    (pmc_deny),
    .pmc_fail    (pmc_fail),
    .settle_done (settle_done),
    .settle_start(settle_start),
    .pmc_req     (pmc_req),
    .iso_en      (iso_en),
    .tile_rst    (tile_rst),
    .pwr_en      (pwr_en),
    .warm        (warm_boot),
    .prep_word_o (prep_w),
    .gate_word_o (gate_w)
  );

  tpg_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .start(settle_start),
    .load (settle_q),
    .done (settle_done)
  );

  assert_wmask_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wm && bus_wdata[B_ENA_REQ]) |=> wm_ack);
  assert_pc_held_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && !wr_lo && !wr_hi) |=> $stable(resume_pc));

endmodule

// File: tb/tile_pwr_seq_bench.sv
`timescale 1ns/1ps
module tile_pwr_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_halted = 1'b0, wake_in = 1'b0, cache_quiet = 1'b1;
  logic        master_quiet = 1'b1, bus_err = 1'b0;
  logic        pmc_grant = 1'b0, pmc_deny = 1'b0, pmc_fail = 1'b0;
  logic        pmc_req, iso_en, pwr_en, tile_rst, warm_boot;
  logic [63:0] resume_pc;
  logic [4:0]  pins;

  always #5 clk = ~clk;

  tile_pwr_seq u_tile_pwr_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_halted(core_halted),
    .wake_in(wake_in), .cache_quiet(cache_quiet), .master_quiet(master_quiet),
    .bus_err(bus_err), .pmc_req(pmc_req), .pmc_grant(pmc_grant),
    .pmc_deny(pmc_deny), .pmc_fail(pmc_fail), .iso_en(iso_en),
    .pwr_en(pwr_en), .tile_rst(tile_rst), .resume_pc(resume_pc),
    .warm_boot(warm_boot)
  );

  // pins = {pmc_req, iso_en, tile_rst, pwr_en, warm_boot}
  assign pins = {pmc_req, iso_en, tile_rst, pwr_en, warm_boot};

  typedef struct {
    string       tag;
    int          src;
    logic [63:0] exp;
  } item_t;

  item_t sbq[$];
  event  mon_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  // monitor: drains the expectation queue against the live outputs
  initial forever begin
    @(mon_ev);
    while (sbq.size() > 0) begin
      item_t       it;
      logic [63:0] act;
      it = sbq.pop_front();
      case (it.src)
        0:       act = {32'h0, bus_rdata};
        1:       act = {59'h0, pins};
        default: act = resume_pc;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic push(input int src, input logic [63:0] e, input string tag);
    item_t it;
    it.tag = tag; it.src = src; it.exp = e;
    sbq.push_back(it);
    -> mon_ev;
    #0.2;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    #0.2;
    push(0, {32'h0, e}, tag);
  endtask

  task automatic chk_pins(input logic [4:0] e, input string tag);
    push(1, {59'h0, e}, tag);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_pins(5'b00010, "R1 pins");
    chk_rd(8'h00, 32'h0, "R1 prepare word");
    chk_rd(8'h04, 32'h0, "R1 gate word");
    chk_rd(8'h20, 32'h1, "R1 wake mask");
    chk_rd(8'h24, 32'h4, "R1 settle count");

    // R2 deny response, then R6 clear on write and R5 disable
    wr(8'h00, 32'h8000_0000);
    tick(1);
    chk_pins(5'b10010, "R2 request raised");
    pmc_deny = 1'b1;
    tick(1);
    pmc_deny = 1'b0;
    chk_rd(8'h00, 32'hC001_0000, "R2 deny captured");
    wr(8'h00, 32'hE001_0000);
    chk_rd(8'h00, 32'hA000_0000, "R6 ack and response cleared");
    tick(1);
    chk_rd(8'h00, 32'h1000_0000, "R5 disable acknowledged");
    chk_pins(5'b00010, "R5 back to running");

    // R2 several reasons at once
    wr(8'h00, 32'h8000_0000);
    tick(1);
    pmc_fail = 1'b1; cache_quiet = 1'b0; bus_err = 1'b1;
    tick(1);
    pmc_fail = 1'b0; cache_quiet = 1'b1; bus_err = 1'b0;
    chk_rd(8'h00, 32'hC006_8000, "R2 fail, cache and bus reasons");
    wr(8'h00, 32'h2000_0000);
    tick(1);

    // R3 wake during prepare, then R5 disable after abort
    wr(8'h00, 32'h8000_0000);
    tick(1);
    chk_pins(5'b10010, "R3 preparing");
    wake_in = 1'b1;
    tick(1);
    wake_in = 1'b0;
    chk_rd(8'h00, 32'h4000_1004, "R3 abort word");
    chk_pins(5'b00010, "R3 request dropped");
    wr(8'h00, 32'h6000_1004);
    chk_rd(8'h00, 32'h2000_0000, "R5 disable pending after abort");
    tick(1);
    chk_rd(8'h00, 32'h1000_0000, "R5 disable accepted after abort");

    // clean prepare, R4 live update
    wr(8'h00, 32'h8000_0000);
    tick(1);
    pmc_grant = 1'b1;
    tick(1);
    pmc_grant = 1'b0;
    chk_rd(8'h00, 32'hC000_0000, "R2 clean grant");
    bus_err = 1'b1;
    tick(1);
    bus_err = 1'b0;
    chk_rd(8'h00, 32'hC000_8000, "R4 live bus error");

    // R7 gate rejected by a busy bus master
    wr(8'h04, 32'h8000_0000);
    tick(1);
    master_quiet = 1'b0; core_halted = 1'b1;
    tick(1);
    master_quiet = 1'b1; core_halted = 1'b0;
    chk_rd(8'h04, 32'h4000_4000, "R7 master not quiet");
    chk_pins(5'b10010, "R7 no power-down on error");

    // R13 gate disable while armed
    wr(8'h04, 32'h8000_0000);
    chk_rd(8'h04, 32'h8000_0000, "R6 gate ack cleared");
    tick(1);
    wr(8'h04, 32'hA000_0000);
    tick(1);
    chk_rd(8'h04, 32'h1000_0000, "R13 gate disable acknowledged");
    chk_pins(5'b10010, "R13 still prepared");

    // R9 wake and halt in the same cycle while armed
    wr(8'h04, 32'h8000_0000);
    tick(1);
    wake_in = 1'b1; core_halted = 1'b1;
    tick(1);
    wake_in = 1'b0; core_halted = 1'b0;
    chk_pins(5'b10010, "R9 abort wins over halt");
    chk_rd(8'h04, 32'h0000_0000, "R9 gate request cleared");
    chk_rd(8'h00, 32'hC000_9000, "R9 wake recorded");
    tick(1);
    chk_pins(5'b10010, "R9 isolation never rises");

    // R11 resume address, R12 wake mask, R8 and R10 full cycle
    wr(8'h10, 32'h89AB_CDEF);
    wr(8'h14, 32'h0123_4567);
    push(2, 64'h0123_4567_89AB_CDEF, "R11 resume_pc pins");
    chk_rd(8'h10, 32'h89AB_CDEF, "R11 low word");
    chk_rd(8'h14, 32'h0123_4567, "R11 high word");
    wr(8'h24, 32'h2);
    wr(8'h20, 32'h8000_0000);
    chk_rd(8'h20, 32'h4000_0000, "R12 mask written");
    wr(8'h04, 32'h8000_0000);
    tick(1);
    core_halted = 1'b1;
    tick(1);
    chk_pins(5'b11010, "R8 isolation first");
    tick(1);
    chk_pins(5'b11110, "R8 reset second");
    tick(1);
    chk_pins(5'b11100, "R8 power removed");
    wake_in = 1'b1;
    tick(2);
    wake_in = 1'b0;
    chk_pins(5'b11100, "R12 masked wake ignored");
    push(2, 64'h0123_4567_89AB_CDEF, "R11 held while gated");
    wr(8'h20, 32'h8000_0001);
    chk_rd(8'h20, 32'h4000_0001, "R12 mask re-enabled");
    core_halted = 1'b0;
    wake_in = 1'b1;
    tick(1);
    wake_in = 1'b0;
    chk_pins(5'b01110, "R10 power restored");
    tick(1);
    chk_pins(5'b01110, "R10 settling 2");
    tick(1);
    chk_pins(5'b01110, "R10 settling 3");
    tick(1);
    chk_pins(5'b00110, "R10 isolation released");
    tick(1);
    chk_pins(5'b00011, "R10 reset released warm");
    chk_rd(8'h04, 32'h4000_0002, "R10 gate warm flag");
    chk_rd(8'h00, 32'h4000_9000, "R10 prepare request cleared");
    push(2, 64'h0123_4567_89AB_CDEF, "R11 kept after wake");

    tick(2);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule